// File: doc/BRIEF.md
# Modified Weight Check Encoder

This block turns an m-bit data word, usually the output lines of a logic function being watched, into a short check word for concurrent error detection. It counts the set bits of the word and keeps only that count modulo M. M is half of the range the check word can represent. The remaining top bit of the check word is a correction bit. This bit is the parity (XOR) of those data bits that a mask input selects. The encoded value is therefore W = (ones mod M) + corr·M.

The mask is an ordinary input. It can be tied to a constant or changed at run time. Changing it lets one data width be checked with different correction rules. A parameter places an optional register stage on the output, so the encoder can sit on a timing boundary. The check width is derived from the data width when the design is elaborated.

Top module: `modwt_encoder`

## Requirements
- R1: For a data width DATA_W (2 to 16), the check word has CHK_W = ceil(log2(DATA_W+1)) bits, and the modulus is M = 2^(CHK_W-1); with DATA_W=5 this gives CHK_W=3 and M=4.
- R2: Bits CHK_W-2..0 of the check word equal the number of ones in the data word modulo M, the smallest non-negative residue (for DATA_W=5 an all-ones word, 5 ones, gives 1).
- R3: Bit CHK_W-1 of the check word is the XOR of every data bit data_i[j] whose mask bit mask_i[j] is 1; mask 5'd8 selects data_i[3] alone, and mask 5'd27 selects data_i[0], data_i[1], data_i[3] and data_i[4].
- R4: With an all-zero mask the correction bit is 0, so the check word equals the ones count modulo M.
- R5: Any two data words that differ in an odd number of bit positions, encoded under the same mask, produce different check words.
- R6: With OUT_REG=1 the check word shows the encoding of the inputs sampled at the previous rising clock edge; with OUT_REG=0 it follows the inputs combinationally.
- R7: While rst_n is low the registered check word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | DATA_W | Data word to encode |
| mask_i | input | DATA_W | Selects the data bits that form the correction bit |
| chk_o | output | CHK_W | Check word (ones mod M) + corr·M |

## Verification
The wrap of the residue and the setting of the correction bit can occur in the same word. An example is a word with M or more ones whose masked bits have odd parity. Here the low field restarts near zero while the top bit is 1. The bench provokes this by sweeping every 5-bit data word under masks 0, 1, 8, 27 and 31. A scoreboard judges each registered result against a popcount and parity model, one cycle after the inputs are applied. Odd-multiplicity flips are driven in back-to-back pairs under a fixed mask, and the second check word must differ from the first.

// File: rtl/modwt_encoder.sv
module modwt_encoder #(
  parameter int DATA_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int CHK_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [CHK_W-1:0] ones;
  logic             corr;
  logic [CHK_W-1:0] code;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CHK_W'(data_i[i]);
  end

  assign corr = ^(data_i & mask_i);
  assign code = {corr, ones[CHK_W-2:0]};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_o <= '0;
        else        chk_o <= code;
      end
    end else begin : g_comb
      assign chk_o = code;
    end
  endgenerate

endmodule

// File: rtl/modwt_encoder_chk.sv
module modwt_encoder_chk #(
  parameter int DATA_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int CHK_W  = $clog2(DATA_W + 1),
  localparam int HALF   = 1 << (CHK_W - 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [CHK_W-1:0]  chk_o
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 3) age <= age + 2'd1;
  end

  generate
    if (OUT_REG) begin : g_reg
      a_r7_reset_zero: assert property (@(posedge clk) !rst_n |-> chk_o == '0);

      a_r2_residue: assert property (@(posedge clk) disable iff (!rst_n)
        age != 0 |-> int'(chk_o[CHK_W-2:0]) == ($countones($past(data_i)) % HALF));

      a_r3_corr_parity: assert property (@(posedge clk) disable iff (!rst_n)
        age != 0 |-> chk_o[CHK_W-1] == ($countones($past(data_i & mask_i)) % 2 == 1));

      a_r4_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 0 && $past(mask_i) == '0) |-> !chk_o[CHK_W-1]);

      a_r5_odd_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3 && $past(mask_i) == $past(mask_i, 2) &&
         ($countones($past(data_i) ^ $past(data_i, 2)) % 2 == 1))
        |-> chk_o != $past(chk_o));
    end else begin : g_comb
      a_r2_residue: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chk_o[CHK_W-2:0]) == ($countones(data_i) % HALF));

      a_r3_corr_parity: assert property (@(posedge clk) disable iff (!rst_n)
        chk_o[CHK_W-1] == ($countones(data_i & mask_i) % 2 == 1));
    end
  endgenerate

endmodule

bind modwt_encoder modwt_encoder_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .mask_i(mask_i), .chk_o(chk_o)
);

// File: tb/test_modwt_encoder.sv
`timescale 1ns/1ps
module test_modwt_encoder;
  localparam int W  = 5;
  localparam int CW = $clog2(W + 1);
  localparam int M  = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] mask_i = '0;
  logic [CW-1:0] chk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  logic [CW-1:0] exp_q[$];
  string         tag_q[$];
  bit            diff_q[$];
  logic [CW-1:0] last_out;

  always #2.5 clk = ~clk;

  modwt_encoder #(.DATA_W(W), .OUT_REG(1'b1)) i_modwt_encoder (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .mask_i(mask_i), .chk_o(chk_o)
  );

  function automatic logic [CW-1:0] model(logic [W-1:0] d, logic [W-1:0] m);
    int ones = 0;
    bit p = 1'b0;
    for (int i = 0; i < W; i++) begin
      ones += d[i];
      if (m[i]) p ^= d[i];
    end
    return CW'((ones % M) + (p ? M : 0));
  endfunction

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] d, logic [W-1:0] m, string tag, bit must_differ);
    @(negedge clk);
    data_i = d;
    mask_i = m;
    exp_q.push_back(model(d, m));
    tag_q.push_back(tag);
    diff_q.push_back(must_differ);
  endtask

  always @(posedge clk) begin
    if (running) begin
      #1;
      if (exp_q.size() != 0) begin
        logic [CW-1:0] e;
        string t;
        bit df;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        df = diff_q.pop_front();
        check(t, chk_o, e);
        if (df) begin
          checks++;
          if (chk_o == last_out) begin
            errors++;
            $display("FAIL R5 actual %0d expected value other than %0d", chk_o, last_out);
          end
        end
        last_out = chk_o;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] masks [5] = '{5'd0, 5'd1, 5'd8, 5'd27, 5'd31};
    data_i = 5'b10110;
    mask_i = 5'b11111;
    repeat (3) @(negedge clk);
    check("R7 reset", chk_o, '0);
    check("R1 width", CW'($bits(chk_o)), CW'(3));
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R6: registered path, R2/R3/R4 over exhaustive sweeps, wrap with correction
    for (int mi = 0; mi < 5; mi++) begin
      for (int d = 0; d < (1 << W); d++) begin
        drive(W'(d), masks[mi], (masks[mi] == 0) ? "R4 zero mask" : "R2/R3 encode R6", 1'b0);
      end
    end
    drive(5'b11111, 5'd0, "R2 all ones", 1'b0);
    drive(5'b01000, 5'd8, "R3 mask8", 1'b0);
    drive(5'b11011, 5'd27, "R3 mask27", 1'b0);
    // R5: odd-multiplicity flips under a fixed mask
    for (int d = 0; d < (1 << W); d += 3) begin
      drive(W'(d), 5'd27, "R5 base", 1'b0);
      drive(W'(d) ^ 5'b00100, 5'd27, "R5 single", 1'b1);
      drive(W'(d), 5'd8, "R5 base", 1'b0);
      drive(W'(d) ^ 5'b10101, 5'd8, "R5 triple", 1'b1);
      drive(W'(d), 5'd0, "R5 base", 1'b0);
      drive(W'(d) ^ 5'b11111, 5'd0, "R5 five", 1'b1);
    end
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 actual %0d pending expected 0", exp_q.size());
    end
    // R7: asynchronous reset clears the register
    rst_n = 1'b0;
    #1;
    check("R7 async reset", chk_o, '0);
    finish_run();
  end
endmodule